// File: doc/BRIEF.md
# Data Access Alignment Fault Checker

This block sits beside the address-generation stage of a load/store pipeline and classifies each data access before it reaches memory. From the low address bits, the access size, the kind of instruction behind the access and a handful of configuration bits, it decides whether an alignment fault must be raised. When it raises one, it also gives the fault status code. When the access is allowed but straddles its natural boundary, it tells downstream logic that the access must be split into aligned pieces.

Two configuration bits select the alignment model. One bit enables unaligned support. The other enables strict checking. With both low the block behaves as a legacy truncating design and never faults. With unaligned support on, plain half and word loads and stores may be misaligned. Block transfers, pairs, atomics, coprocessor transfers and loads into the program counter still fault when they are not word aligned. A misaligned single access to strongly ordered or device memory also faults, but only when the MMU and the extended-page mode are both enabled. The verdict passes through an output register that a parameter can remove.

Top module: `acc_align_checker`

## Requirements
- R1: A byte access (size code 0) never raises a fault, whatever its kind, address or mode bits.
- R2: With unaligned enable and strict check both 0, no access raises a fault or sets the split flag.
- R3: With strict check 1, a single (kind 0) or program-counter load (kind 5) faults when it is a halfword (size 1) with address bit 0 set, or a word (size 2) with address bits [1:0] nonzero. Otherwise it does not fault.
- R4: With unaligned enable 0 and strict check 1, a pair access (kind 2) faults unless address bits [2:0] are 000. Block (kind 1), atomic (kind 3) and coprocessor (kind 4) accesses fault unless bits [1:0] are 00. A doubleword size on a single kind follows the pair rule.
- R5: With unaligned enable 1 and either strict setting, block, pair, atomic and coprocessor accesses of size halfword or larger fault when address bits [1:0] are nonzero.
- R6: With unaligned enable 1 and strict check 0, a misaligned single halfword or word access to normal memory does not fault.
- R7: With unaligned enable 1, a misaligned program-counter load always faults.
- R8: With unaligned enable 1 and strict check 0, a misaligned single access whose memory-type input marks strongly ordered or device memory faults only when both the MMU enable and the extended-page bit are 1.
- R9: The status output equals 5'b00001 whenever the fault flag is 1, and zero whenever it is 0.
- R10: The split flag is 1 exactly when unaligned enable is 1, no fault is raised, the size is not byte, and the access is misaligned to its own size (half: bit 0, word: bits [1:0], doubleword: bits [2:0]).
- R11: With the output register present (default), outputs show the verdict for the inputs of the previous clock edge, and synchronous reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | AW (32) | Access address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| acc_kind | input | 3 | 0 single, 1 block, 2 pair, 3 atomic, 4 coprocessor, 5 PC load; 6 and 7 act as single |
| cfg_unaligned_en | input | 1 | Unaligned access support enable |
| cfg_strict_chk | input | 1 | Strict alignment check enable |
| cfg_mmu_en | input | 1 | MMU enable |
| cfg_ext_page | input | 1 | Extended-page mode bit |
| acc_strict_mem | input | 1 | Target is strongly ordered or device memory |
| flt_hit | output | 1 | Alignment fault |
| flt_status | output | FSW (5) | Fault status code |
| acc_split | output | 1 | Access allowed but needs unaligned handling |

## Verification
The hardest case to reach is the device-memory fault. It needs unaligned support on, strict checking off, a misaligned single access, the memory-type input set, and both the MMU and extended-page bits high. The stimulus table holds that exact setting and then clears each enabling bit in turn. This shows the fault appears only with both bits set, and that the access falls back to the split path when either is clear. The pair accesses at word-aligned but not doubleword-aligned addresses are also covered, because they fault in one mode and split in the other.

// File: rtl/acc_align_pkg.sv
package acc_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        K_SINGLE = 3'd0,
        K_MULTI  = 3'd1,
        K_PAIR   = 3'd2,
        K_SWAP   = 3'd3,
        K_COPRO  = 3'd4,
        K_PCLOAD = 3'd5
    } acc_kind_e;

    typedef struct packed {
        logic nat;    // misaligned to its own size
        logic word;   // low two bits nonzero, size above byte
        logic dword;  // low three bits nonzero, size above byte
        logic sized;  // size above byte
    } mis_t;

    typedef struct packed {
        logic fault;
        logic split;
    } verdict_t;

    localparam int FSW_DEF = 5;

    function automatic logic nat_misaligned(input acc_size_e sz, input logic [2:0] lo);
        case (sz)
            SZ_HALF:  return lo[0];
            SZ_WORD:  return |lo[1:0];
            SZ_DWORD: return |lo[2:0];
            default:  return 1'b0;
        endcase
    endfunction

    // Single-kind doubleword accesses follow the pair rules; unknown kinds act as single.
    function automatic acc_kind_e effective_kind(input logic [2:0] raw, input acc_size_e sz);
        acc_kind_e k;
        if (raw > 3'd5) k = K_SINGLE;
        else            k = acc_kind_e'(raw);
        if (k == K_SINGLE && sz == SZ_DWORD) k = K_PAIR;
        return k;
    endfunction

endpackage

// File: rtl/acc_misalign_detect.sv
module acc_misalign_detect
    import acc_align_pkg::*;
(
    input  logic [2:0]  addr_lo,
    input  acc_size_e   size,
    output mis_t        mis
);
    always_comb begin
        mis.sized = (size != SZ_BYTE);
        mis.nat   = nat_misaligned(size, addr_lo);
        mis.word  = mis.sized && (addr_lo[1:0] != 2'b00);
        mis.dword = mis.sized && (addr_lo != 3'b000);
    end
endmodule

// File: rtl/acc_fault_rules.sv
module acc_fault_rules
    import acc_align_pkg::*;
(
    input  mis_t       mis,
    input  acc_kind_e  kind,
    input  logic       u_en,
    input  logic       a_en,
    input  logic       mmu_en,
    input  logic       ext_page,
    input  logic       strict_mem,
    output verdict_t   verdict
);
    logic legacy_fault;
    logic ext_fault;
    logic dev_trap;

    assign dev_trap = strict_mem && mmu_en && ext_page;

    // Legacy model: only the strict-check bit can produce a fault.
    always_comb begin
        legacy_fault = 1'b0;
        if (a_en) begin
            case (kind)
                K_SINGLE, K_PCLOAD: legacy_fault = mis.nat;
                K_PAIR:             legacy_fault = mis.dword;
                default:            legacy_fault = mis.word;
            endcase
        end
    end

    // Extended model: unaligned singles allowed unless strict or device trap.
    always_comb begin
        case (kind)
            K_SINGLE: ext_fault = mis.nat && (a_en || dev_trap);
            K_PCLOAD: ext_fault = mis.nat;
            default:  ext_fault = mis.word;
        endcase
    end

    always_comb begin
        verdict.fault = mis.sized && (u_en ? ext_fault : legacy_fault);
        verdict.split = u_en && mis.sized && mis.nat && !verdict.fault;
    end
endmodule

// File: rtl/acc_out_stage.sv
module acc_out_stage
    import acc_align_pkg::*;
#(
    parameter bit             REG_OUT   = 1'b1,
    parameter int             FSW       = FSW_DEF,
    parameter logic [FSW-1:0] FSC_ALIGN = FSW'(1)
) (
    input  logic           clk,
    input  logic           rst,
    input  verdict_t       verdict,
    output logic           fault_o,
    output logic [FSW-1:0] status_o,
    output logic           split_o
);
    logic [FSW-1:0] status_d;
    assign status_d = verdict.fault ? FSC_ALIGN : '0;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    fault_o  <= 1'b0;
                    status_o <= '0;
                    split_o  <= 1'b0;
                end else begin
                    fault_o  <= verdict.fault;
                    status_o <= status_d;
                    split_o  <= verdict.split;
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign fault_o  = verdict.fault;
            assign status_o = status_d;
            assign split_o  = verdict.split;
        end
    endgenerate
endmodule

// File: rtl/acc_align_checker.sv
module acc_align_checker
    import acc_align_pkg::*;
#(
    parameter int             AW        = 32,
    parameter bit             REG_OUT   = 1'b1,
    parameter int             FSW       = FSW_DEF,
    parameter logic [FSW-1:0] FSC_ALIGN = FSW'(1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  acc_addr,
    input  logic [1:0]     acc_size,
    input  logic [2:0]     acc_kind,
    input  logic           cfg_unaligned_en,
    input  logic           cfg_strict_chk,
    input  logic           cfg_mmu_en,
    input  logic           cfg_ext_page,
    input  logic           acc_strict_mem,
    output logic           flt_hit,
    output logic [FSW-1:0] flt_status,
    output logic           acc_split
);
    localparam int LOW_BITS = 3;

    acc_size_e size_e;
    acc_kind_e kind_e;
    mis_t      mis;
    verdict_t  verdict;
    logic      unused_addr_hi;

    assign size_e         = acc_size_e'(acc_size);
    assign kind_e         = effective_kind(acc_kind, size_e);
    assign unused_addr_hi = ^acc_addr[AW-1:LOW_BITS];

    acc_misalign_detect u_detect (
        .addr_lo (acc_addr[LOW_BITS-1:0]),
        .size    (size_e),
        .mis     (mis)
    );

    acc_fault_rules u_rules (
        .mis        (mis),
        .kind       (kind_e),
        .u_en       (cfg_unaligned_en),
        .a_en       (cfg_strict_chk),
        .mmu_en     (cfg_mmu_en),
        .ext_page   (cfg_ext_page),
        .strict_mem (acc_strict_mem),
        .verdict    (verdict)
    );

    acc_out_stage #(
        .REG_OUT   (REG_OUT),
        .FSW       (FSW),
        .FSC_ALIGN (FSC_ALIGN)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .fault_o  (flt_hit),
        .status_o (flt_status),
        .split_o  (acc_split)
    );
endmodule

// File: rtl/acc_align_checker_sva.sv
module acc_align_checker_sva #(
    parameter int             AW        = 32,
    parameter bit             REG_OUT   = 1'b1,
    parameter int             FSW       = 5,
    parameter logic [FSW-1:0] FSC_ALIGN = FSW'(1)
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  acc_addr,
    input logic [1:0]     acc_size,
    input logic [2:0]     acc_kind,
    input logic           cfg_unaligned_en,
    input logic           cfg_strict_chk,
    input logic           flt_hit,
    input logic [FSW-1:0] flt_status,
    input logic           acc_split
);
    assert_status_on_fault_R9: assert property (@(posedge clk) disable iff (rst)
        flt_hit |-> flt_status == FSC_ALIGN);
    assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !flt_hit |-> flt_status == '0);
    assert_split_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(flt_hit && acc_split));

    generate
        if (REG_OUT) begin : g_seq
            assert_byte_never_R1: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(acc_size) == 2'd0) |-> !flt_hit);
            assert_legacy_quiet_R2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(cfg_unaligned_en) && !$past(cfg_strict_chk))
                |-> (!flt_hit && !acc_split));
            assert_block_word_R5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_unaligned_en) && $past(acc_size) != 2'd0
                 && ($past(acc_kind) == 3'd1 || $past(acc_kind) == 3'd3
                     || $past(acc_kind) == 3'd4)
                 && $past(acc_addr[1:0]) != 2'b00) |-> flt_hit);
            assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_unaligned_en) && $past(acc_kind) == 3'd5
                 && $past(acc_size) == 2'd2 && $past(acc_addr[1:0]) != 2'b00) |-> flt_hit);
            assert_split_mode_R10: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && acc_split) |-> $past(cfg_unaligned_en));
            assert_reset_clear_R11: assert property (@(posedge clk)
                $past(rst) |-> (!flt_hit && !acc_split && flt_status == '0));
        end
    endgenerate
endmodule

bind acc_align_checker acc_align_checker_sva #(
    .AW(AW), .REG_OUT(REG_OUT), .FSW(FSW), .FSC_ALIGN(FSC_ALIGN)
) u_sva (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_kind(acc_kind), .cfg_unaligned_en(cfg_unaligned_en),
    .cfg_strict_chk(cfg_strict_chk), .flt_hit(flt_hit),
    .flt_status(flt_status), .acc_split(acc_split)
);

// File: tb/acc_align_checker_tb.sv
module acc_align_checker_tb;
    localparam int AW = 32;
    localparam int NV = 24;
    // {u, a, mmu, xp, strict_mem, kind[2:0], size[1:0], addr[31:0], exp_fault, exp_split}
    localparam logic [43:0] VEC [NV] = '{
        {1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,2'd0,32'h0000_0003,1'b0,1'b0}, // R1
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd3,2'd0,32'h8000_0001,1'b0,1'b0}, // R1
        {1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,2'd2,32'h0000_0002,1'b0,1'b0}, // R2
        {1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,2'd3,32'h0000_0004,1'b0,1'b0}, // R2
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd1,32'h1234_0001,1'b1,1'b0}, // R3
        {1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,2'd2,32'h0000_0002,1'b1,1'b0}, // R3
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd1,32'h0000_0002,1'b0,1'b0}, // R3
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd2,2'd3,32'h0000_0004,1'b1,1'b0}, // R4
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd2,2'd3,32'hFFFF_FFF8,1'b0,1'b0}, // R4
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd1,2'd2,32'h0000_0001,1'b1,1'b0}, // R4
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd1,2'd2,32'h0000_0002,1'b1,1'b0}, // R5
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,2'd2,32'h0000_0001,1'b1,1'b0}, // R5
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,2'd2,32'h0000_0003,1'b1,1'b0}, // R5
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,2'd3,32'h0000_0004,1'b0,1'b1}, // R5 R10
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,2'd3,32'h0000_0006,1'b1,1'b0}, // R5
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd2,32'h0000_0001,1'b0,1'b1}, // R6
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd1,32'h0000_0013,1'b0,1'b1}, // R6
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,2'd2,32'h0000_0002,1'b1,1'b0}, // R7
        {1'b0,1'b0,1'b0,1'b0,1'b0,3'd5,2'd2,32'h0000_0002,1'b0,1'b0}, // R2
        {1'b1,1'b0,1'b1,1'b1,1'b1,3'd0,2'd2,32'h0000_0001,1'b1,1'b0}, // R8
        {1'b1,1'b0,1'b1,1'b0,1'b1,3'd0,2'd2,32'h0000_0001,1'b0,1'b1}, // R8
        {1'b1,1'b0,1'b0,1'b1,1'b1,3'd0,2'd2,32'h0000_0001,1'b0,1'b1}, // R8
        {1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd2,32'h0000_0004,1'b0,1'b0}, // R10
        {1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd3,32'h0000_0004,1'b1,1'b0}  // R4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_size = '0;
    logic [2:0]    acc_kind = '0;
    logic          cfg_unaligned_en = 1'b0, cfg_strict_chk = 1'b0;
    logic          cfg_mmu_en = 1'b0, cfg_ext_page = 1'b0, acc_strict_mem = 1'b0;
    logic          flt_hit, acc_split;
    logic [4:0]    flt_status;
    int            checks = 0, failures = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    acc_align_checker u_dut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_kind(acc_kind), .cfg_unaligned_en(cfg_unaligned_en),
        .cfg_strict_chk(cfg_strict_chk), .cfg_mmu_en(cfg_mmu_en),
        .cfg_ext_page(cfg_ext_page), .acc_strict_mem(acc_strict_mem),
        .flt_hit(flt_hit), .flt_status(flt_status), .acc_split(acc_split)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s {fault,status,split} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [43:0] v);
        cfg_unaligned_en = v[43]; cfg_strict_chk = v[42];
        cfg_mmu_en = v[41]; cfg_ext_page = v[40]; acc_strict_mem = v[39];
        acc_kind = v[38:36]; acc_size = v[35:34]; acc_addr = v[33:2];
    endtask

    function automatic logic [6:0] expv(input logic f, input logic s);
        return {f, (f ? 5'd1 : 5'd0), s};
    endfunction

    initial begin
        // R11: reset holds outputs at zero even with a faulting input present
        apply({1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd2,32'h1,1'b0,1'b0});
        repeat (3) @(negedge clk);
        check("R11 reset", {flt_hit, flt_status, acc_split}, 7'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R1-R10 vec%0d", i), {flt_hit, flt_status, acc_split},
                  expv(VEC[i][1], VEC[i][0]));
        end

        // R11: one-cycle latency; output keeps old verdict until next edge
        apply({1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,2'd2,32'h2,1'b0,1'b0});
        @(negedge clk);
        check("R11 fault", {flt_hit, flt_status, acc_split}, expv(1'b1, 1'b0));
        apply({1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd2,32'h0,1'b0,1'b0});
        #1;
        check("R11 hold", {flt_hit, flt_status, acc_split}, expv(1'b1, 1'b0));
        @(negedge clk);
        check("R11 update", {flt_hit, flt_status, acc_split}, expv(1'b0, 1'b0));

        // R11: synchronous reset clears a held split verdict
        apply({1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd1,32'h1,1'b0,1'b0});
        @(negedge clk);
        check("R10 split", {flt_hit, flt_status, acc_split}, expv(1'b0, 1'b1));
        rst = 1'b1;
        @(negedge clk);
        check("R11 reclear", {flt_hit, flt_status, acc_split}, 7'd0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule